// File: doc/BRIEF.md
# Mixed-width dual-port memory

A synchronous two-port memory of 16,384 data bits, plus one parity bit per stored byte. Each port has its own enable, write enable, address, data and parity inputs, and a registered data and parity output. Both ports share one clock. A parameter sets each port's data width to 1, 2, 4, 8, 16 or 32 bits. The address width follows from that choice, so the two ports can view the same storage at different aspect ratios. A narrow port sees slices of a wide word. A wide port sees consecutive narrow words packed side by side.

A second parameter sets each port's write mode. It decides what the port's output shows during its own write: the data being written (write-first) or the previous contents (read-first). Widths of 8 bits and above carry one parity lane per byte. The parity lanes are stored next to their bytes, so they keep their byte alignment across ports of different widths. The active-low reset clears only the output registers; the stored contents are not reset.

Top module: `mixed_dpram`

## Requirements
- R1: A port of width W has 14 − log2(W) address bits. With the default widths, port A is 8 bits wide with 11 address bits, and port B is 32 bits wide with 9 address bits. The highest address (2047 on A, 511 on B) and address 0 both reach valid storage: A address 2047 is byte lane 3 of B word 511, and A address 0 is byte lane 0 of B word 0.
- R2: On a clock edge where both enable and write enable are high, the data and parity inputs are stored at the addressed location.
- R3: On a clock edge where enable is high and write enable is low, the stored data and parity at the address appear on the outputs right after that edge.
- R4: A port in write-first mode (the default for port A) shows the data and parity it is writing on its outputs right after the write edge.
- R5: A port in read-first mode (the default for port B) shows the contents the location held before the write, right after the write edge.
- R6: While enable is low, the outputs hold their previous value and a high write enable stores nothing.
- R7: Narrow word k of wide word j is found at narrow address j·L + k, where L is the wide width divided by the narrow width. It occupies bits [k·Wn +: Wn], so the lowest narrow address sits in the least significant bits.
- R8: A wide word written on the wide port reads back on the narrow port as successive slices, starting with the least significant slice at the lowest narrow address.
- R9: A port of width 8 or more has W/8 parity bits. Parity bit k goes with byte k of the port's word, so parity written through the 8-bit port shows up at bit position k of the 32-bit port's parity, and the reverse also holds.
- R10: While reset is low, both ports' data and parity outputs are zero.
- R11: The two ports can write different locations on the same edge, and both writes are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Active-low reset of the output registers |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| addr_a | input | 14 − log2(WIDTH_A) | Port A address |
| din_a | input | WIDTH_A | Port A write data |
| dinp_a | input | max(WIDTH_A/8, 1) | Port A write parity (ignored below width 8) |
| dout_a | output | WIDTH_A | Port A read data |
| doutp_a | output | max(WIDTH_A/8, 1) | Port A read parity (zero below width 8) |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| addr_b | input | 14 − log2(WIDTH_B) | Port B address |
| din_b | input | WIDTH_B | Port B write data |
| dinp_b | input | max(WIDTH_B/8, 1) | Port B write parity (ignored below width 8) |
| dout_b | output | WIDTH_B | Port B read data |
| doutp_b | output | max(WIDTH_B/8, 1) | Port B read parity (zero below width 8) |

## Verification
The bench writes bytes through the narrow port and reads them through the wide port, and the reverse. A design with the lanes reversed or the address split wrong would return bytes in swapped order or from a neighbouring word. It also checks parity bits at specific lane positions, which catches parity that is stored per word instead of per byte.

A write-first port that returned stale data, or a read-first port that returned the new data, fails the same-edge output checks. So does a port whose output changes or whose memory is written while enable is low.

Further tests cover the two address extremes and two ports writing at once. These catch an address path that is one bit short, and a shared write path that drops one port's write.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic {WR_FIRST = 1'b0, RD_FIRST = 1'b1} wr_mode_e;

  localparam int TOTAL_BITS = 16384;
  localparam int WORD_W     = 32;
  localparam int WORD_P     = WORD_W / 8;

  function automatic int clog2i(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return r;
  endfunction

  localparam int DEPTH  = TOTAL_BITS / WORD_W;
  localparam int IDX_W  = clog2i(DEPTH);
  localparam int LANE_W = clog2i(WORD_W);

  // address bits for a port of width w
  function automatic int addr_w(input int w);
    return clog2i(TOTAL_BITS) - clog2i(w);
  endfunction

  // parity bits carried by a port of width w
  function automatic int par_w(input int w);
    return (w >= 8) ? w / 8 : 0;
  endfunction

  // parity port width, kept at least one bit
  function automatic int par_port_w(input int w);
    return (par_w(w) > 0) ? par_w(w) : 1;
  endfunction

  // low address bits that pick the lane inside a stored word
  function automatic int lane_bits(input int w);
    return clog2i(WORD_W / w);
  endfunction

  // ones over bits [lane*w +: w] of a word
  function automatic logic [WORD_W-1:0] lane_mask(input int w, input int lane);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[lane*w + i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int       W    = 8,
  parameter wr_mode_e MODE = WR_FIRST,
  localparam int      AW   = addr_w(W),
  localparam int      P    = par_w(W),
  localparam int      PX   = par_port_w(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [W-1:0]      din,
  input  logic [PX-1:0]     dinp,
  input  logic [WORD_W-1:0] rword,
  input  logic [WORD_P-1:0] rpar,
  output logic              wr,
  output logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] wmask,
  output logic [WORD_W-1:0] wdata,
  output logic [WORD_P-1:0] pmask,
  output logic [WORD_P-1:0] pdata,
  output logic [W-1:0]      dout,
  output logic [PX-1:0]     doutp
);

  localparam int LB = lane_bits(W);

  logic [LANE_W-1:0] lane;
  logic [W-1:0]      rd;
  logic [PX-1:0]     rdp;
  logic [PX-1:0]     wfp;

  generate
    if (LB == 0) begin : g_full
      assign lane = '0;
      assign idx  = addr;
    end else begin : g_part
      assign lane = LANE_W'(addr[LB-1:0]);
      assign idx  = addr[AW-1:LB];
    end
  endgenerate

  assign wr    = en & we;
  assign wmask = lane_mask(W, int'(lane));
  assign wdata = WORD_W'(din) << (int'(lane) * W);
  assign rd    = W'(rword >> (int'(lane) * W));

  generate
    if (P > 0) begin : g_par
      assign pmask = WORD_P'(lane_mask(P, int'(lane)));
      assign pdata = WORD_P'(WORD_P'(dinp) << (int'(lane) * P));
      assign rdp   = PX'(rpar >> (int'(lane) * P));
      assign wfp   = dinp;
    end else begin : g_nopar
      logic unused_par;
      assign unused_par = ^{dinp, rpar};
      assign pmask = '0;
      assign pdata = '0;
      assign rdp   = '0;
      assign wfp   = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout  <= '0;
      doutp <= '0;
    end else if (en) begin
      if (we && (MODE == WR_FIRST)) begin
        dout  <= din;
        doutp <= wfp;
      end else begin
        dout  <= rd;
        doutp <= rdp;
      end
    end
  end

endmodule

// File: rtl/dpram_array.sv
module dpram_array
  import dpram_pkg::*;
(
  input  logic              clk,
  input  logic              wr_a,
  input  logic [IDX_W-1:0]  idx_a,
  input  logic [WORD_W-1:0] wmask_a,
  input  logic [WORD_W-1:0] wdata_a,
  input  logic [WORD_P-1:0] pmask_a,
  input  logic [WORD_P-1:0] pdata_a,
  input  logic              wr_b,
  input  logic [IDX_W-1:0]  idx_b,
  input  logic [WORD_W-1:0] wmask_b,
  input  logic [WORD_W-1:0] wdata_b,
  input  logic [WORD_P-1:0] pmask_b,
  input  logic [WORD_P-1:0] pdata_b,
  output logic [WORD_W-1:0] rword_a,
  output logic [WORD_P-1:0] rpar_a,
  output logic [WORD_W-1:0] rword_b,
  output logic [WORD_P-1:0] rpar_b
);

  logic [WORD_W-1:0] mem  [DEPTH];
  logic [WORD_P-1:0] pmem [DEPTH];

  logic              same_word;
  logic [WORD_W-1:0] merged_a, base_b, merged_b;
  logic [WORD_P-1:0] pmerged_a, pbase_b, pmerged_b;

  // both ports writing one word: port B's lanes are merged over port A's result
  assign same_word = wr_a & wr_b & (idx_a == idx_b);

  assign merged_a  = (mem[idx_a] & ~wmask_a) | (wdata_a & wmask_a);
  assign base_b    = same_word ? merged_a : mem[idx_b];
  assign merged_b  = (base_b & ~wmask_b) | (wdata_b & wmask_b);

  assign pmerged_a = (pmem[idx_a] & ~pmask_a) | (pdata_a & pmask_a);
  assign pbase_b   = same_word ? pmerged_a : pmem[idx_b];
  assign pmerged_b = (pbase_b & ~pmask_b) | (pdata_b & pmask_b);

  always_ff @(posedge clk) begin
    if (wr_a) begin
      mem[idx_a]  <= merged_a;
      pmem[idx_a] <= pmerged_a;
    end
    if (wr_b) begin
      mem[idx_b]  <= merged_b;
      pmem[idx_b] <= pmerged_b;
    end
  end

  assign rword_a = mem[idx_a];
  assign rpar_a  = pmem[idx_a];
  assign rword_b = mem[idx_b];
  assign rpar_b  = pmem[idx_b];

endmodule

// File: rtl/mixed_dpram.sv
module mixed_dpram
  import dpram_pkg::*;
#(
  parameter int       WIDTH_A = 8,
  parameter int       WIDTH_B = 32,
  parameter wr_mode_e MODE_A  = WR_FIRST,
  parameter wr_mode_e MODE_B  = RD_FIRST
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en_a,
  input  logic                             we_a,
  input  logic [addr_w(WIDTH_A)-1:0]       addr_a,
  input  logic [WIDTH_A-1:0]               din_a,
  input  logic [par_port_w(WIDTH_A)-1:0]   dinp_a,
  output logic [WIDTH_A-1:0]               dout_a,
  output logic [par_port_w(WIDTH_A)-1:0]   doutp_a,
  input  logic                             en_b,
  input  logic                             we_b,
  input  logic [addr_w(WIDTH_B)-1:0]       addr_b,
  input  logic [WIDTH_B-1:0]               din_b,
  input  logic [par_port_w(WIDTH_B)-1:0]   dinp_b,
  output logic [WIDTH_B-1:0]               dout_b,
  output logic [par_port_w(WIDTH_B)-1:0]   doutp_b
);

  logic              wr_a, wr_b;
  logic [IDX_W-1:0]  idx_a, idx_b;
  logic [WORD_W-1:0] wmask_a, wdata_a, wmask_b, wdata_b;
  logic [WORD_P-1:0] pmask_a, pdata_a, pmask_b, pdata_b;
  logic [WORD_W-1:0] rword_a, rword_b;
  logic [WORD_P-1:0] rpar_a, rpar_b;

  dpram_port #(.W(WIDTH_A), .MODE(MODE_A)) u_pa (
    .clk(clk), .rst_n(rst_n), .en(en_a), .we(we_a), .addr(addr_a),
    .din(din_a), .dinp(dinp_a), .rword(rword_a), .rpar(rpar_a),
    .wr(wr_a), .idx(idx_a), .wmask(wmask_a), .wdata(wdata_a),
    .pmask(pmask_a), .pdata(pdata_a), .dout(dout_a), .doutp(doutp_a)
  );

  dpram_port #(.W(WIDTH_B), .MODE(MODE_B)) u_pb (
    .clk(clk), .rst_n(rst_n), .en(en_b), .we(we_b), .addr(addr_b),
    .din(din_b), .dinp(dinp_b), .rword(rword_b), .rpar(rpar_b),
    .wr(wr_b), .idx(idx_b), .wmask(wmask_b), .wdata(wdata_b),
    .pmask(pmask_b), .pdata(pdata_b), .dout(dout_b), .doutp(doutp_b)
  );

  dpram_array u_mem (
    .clk(clk),
    .wr_a(wr_a), .idx_a(idx_a), .wmask_a(wmask_a), .wdata_a(wdata_a),
    .pmask_a(pmask_a), .pdata_a(pdata_a),
    .wr_b(wr_b), .idx_b(idx_b), .wmask_b(wmask_b), .wdata_b(wdata_b),
    .pmask_b(pmask_b), .pdata_b(pdata_b),
    .rword_a(rword_a), .rpar_a(rpar_a), .rword_b(rword_b), .rpar_b(rpar_b)
  );

endmodule

// File: rtl/dpram_chk.sv
module dpram_chk
  import dpram_pkg::*;
#(
  parameter int       WIDTH_A = 8,
  parameter int       WIDTH_B = 32,
  parameter wr_mode_e MODE_A  = WR_FIRST,
  parameter wr_mode_e MODE_B  = RD_FIRST,
  localparam int      PA      = par_w(WIDTH_A),
  localparam int      PB      = par_w(WIDTH_B)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           en_a,
  input logic                           we_a,
  input logic [WIDTH_A-1:0]             din_a,
  input logic [par_port_w(WIDTH_A)-1:0] dinp_a,
  input logic [WIDTH_A-1:0]             dout_a,
  input logic [par_port_w(WIDTH_A)-1:0] doutp_a,
  input logic                           en_b,
  input logic                           we_b,
  input logic [WIDTH_B-1:0]             din_b,
  input logic [par_port_w(WIDTH_B)-1:0] dinp_b,
  input logic [WIDTH_B-1:0]             dout_b,
  input logic [par_port_w(WIDTH_B)-1:0] doutp_b,
  input logic                           wr_a,
  input logic                           wr_b
);

  // R10
  rst_clears_a_chk: assert property (@(posedge clk)
    !rst_n |=> (dout_a == '0) && (doutp_a == '0));

  // R10
  rst_clears_b_chk: assert property (@(posedge clk)
    !rst_n |=> (dout_b == '0) && (doutp_b == '0));

  // R6
  hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_a |=> $stable(dout_a) && $stable(doutp_a));

  // R6
  hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_b |=> $stable(dout_b) && $stable(doutp_b));

  // R6
  no_write_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_a |-> !wr_a);

  // R6
  no_write_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_b |-> !wr_b);

  // R4
  wr_first_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE_A == WR_FIRST) && en_a && we_a |=>
      (dout_a == $past(din_a)) && ((PA == 0) || (doutp_a == $past(dinp_a))));

  // R4
  wr_first_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (MODE_B == WR_FIRST) && en_b && we_b |=>
      (dout_b == $past(din_b)) && ((PB == 0) || (doutp_b == $past(dinp_b))));

endmodule

bind mixed_dpram dpram_chk #(
  .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B), .MODE_A(MODE_A), .MODE_B(MODE_B)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .en_a(en_a), .we_a(we_a), .din_a(din_a), .dinp_a(dinp_a),
  .dout_a(dout_a), .doutp_a(doutp_a),
  .en_b(en_b), .we_b(we_b), .din_b(din_b), .dinp_b(dinp_b),
  .dout_b(dout_b), .doutp_b(doutp_b),
  .wr_a(wr_a), .wr_b(wr_b)
);

// File: tb/mixed_dpram_test.sv
module mixed_dpram_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_a = 1'b0, we_a = 1'b0;
  logic [10:0] addr_a = '0;
  logic [7:0]  din_a = '0;
  logic [0:0]  dinp_a = '0;
  logic [7:0]  dout_a;
  logic [0:0]  doutp_a;
  logic        en_b = 1'b0, we_b = 1'b0;
  logic [8:0]  addr_b = '0;
  logic [31:0] din_b = '0;
  logic [3:0]  dinp_b = '0;
  logic [31:0] dout_b;
  logic [3:0]  doutp_b;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  // flat bit-level model: byte n at bits [8n +: 8], parity bit n with byte n
  logic [16383:0] mdat = '0;
  logic [2047:0]  mpar = '0;

  always #5 clk = ~clk;

  mixed_dpram uut (
    .clk(clk), .rst_n(rst_n),
    .en_a(en_a), .we_a(we_a), .addr_a(addr_a), .din_a(din_a), .dinp_a(dinp_a),
    .dout_a(dout_a), .doutp_a(doutp_a),
    .en_b(en_b), .we_b(we_b), .addr_b(addr_b), .din_b(din_b), .dinp_b(dinp_b),
    .dout_b(dout_b), .doutp_b(doutp_b)
  );

  task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [8:0] exp_a(input int a);
    return {mpar[a], mdat[a*8 +: 8]};
  endfunction

  function automatic logic [35:0] exp_b(input int a);
    return {mpar[a*4 +: 4], mdat[a*32 +: 32]};
  endfunction

  task automatic set_a(input bit e, input bit w, input int a, input logic [7:0] d, input logic p);
    en_a = e; we_a = w; addr_a = 11'(a); din_a = d; dinp_a = p;
    if (e && w) begin
      mdat[a*8 +: 8] = d;
      mpar[a] = p;
    end
  endtask

  task automatic set_b(input bit e, input bit w, input int a, input logic [31:0] d, input logic [3:0] p);
    en_b = e; we_b = w; addr_b = 9'(a); din_b = d; dinp_b = p;
    if (e && w) begin
      mdat[a*32 +: 32] = d;
      mpar[a*4 +: 4] = p;
    end
  endtask

  task automatic idle();
    en_a = 1'b0; we_a = 1'b0; en_b = 1'b0; we_b = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(); step();
    chk("R10 dout_a", 36'(dout_a), 36'h0);
    chk("R10 doutp_a", 36'(doutp_a), 36'h0);
    chk("R10 dout_b", 36'(dout_b), 36'h0);
    chk("R10 doutp_b", 36'(doutp_b), 36'h0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_write_first();
    set_a(1, 1, 5, 8'hA5, 1'b1); step();
    chk("R4 write-first A", 36'({doutp_a, dout_a}), 36'({1'b1, 8'hA5}));
    set_a(1, 0, 5, 8'h00, 1'b0); step();
    chk("R2/R3 read back A", 36'({doutp_a, dout_a}), 36'(exp_a(5)));
    idle();
  endtask

  task automatic t_read_first();
    logic [35:0] old;
    set_b(1, 1, 3, 32'h11223344, 4'hA); step();
    old = exp_b(3);
    set_b(1, 1, 3, 32'hDEADBEEF, 4'h5); step();
    chk("R5 read-first B", {doutp_b, dout_b}, old);
    set_b(1, 0, 3, 32'h0, 4'h0); step();
    chk("R2/R3 read back B", {doutp_b, dout_b}, exp_b(3));
    idle();
  endtask

  task automatic t_narrow_to_wide();
    logic [3:0] pb = 4'b1101;
    for (int k = 0; k < 4; k++) begin
      set_a(1, 1, 40 + k, 8'(k + 1), pb[k]); step();
    end
    idle();
    set_b(1, 0, 10, 32'h0, 4'h0); step();
    chk("R7 packed word", 36'(dout_b), 36'h0_0403_0201);
    chk("R9 parity lanes wide", 36'(doutp_b), 36'(4'b1101));
    idle();
  endtask

  task automatic t_wide_to_narrow();
    logic [7:0] eb [4] = '{8'h0D, 8'hF0, 8'hFE, 8'hCA};
    logic [3:0] ep = 4'b0110;
    set_b(1, 1, 20, 32'hCAFEF00D, 4'b0110); step();
    idle();
    for (int k = 0; k < 4; k++) begin
      set_a(1, 0, 80 + k, 8'h0, 1'b0); step();
      chk("R8 slice", 36'(dout_a), 36'(eb[k]));
      chk("R9 parity lane narrow", 36'(doutp_a), 36'(ep[k]));
    end
    idle();
  endtask

  task automatic t_disable();
    logic [8:0]  hold_a;
    logic [35:0] hold_b;
    set_b(1, 0, 3, 32'h0, 4'h0); step();
    idle();
    hold_a = {doutp_a, dout_a};
    hold_b = {doutp_b, dout_b};
    en_a = 1'b0; we_a = 1'b1; addr_a = 11'd5; din_a = 8'hFF; dinp_a = 1'b0;
    en_b = 1'b0; we_b = 1'b1; addr_b = 9'd3; din_b = 32'h0; dinp_b = 4'h0;
    step(); step();
    chk("R6 hold A", 36'({doutp_a, dout_a}), 36'(hold_a));
    chk("R6 hold B", {doutp_b, dout_b}, hold_b);
    idle();
    set_a(1, 0, 5, 8'h0, 1'b0);
    set_b(1, 0, 3, 32'h0, 4'h0);
    step();
    chk("R6 no write A", 36'({doutp_a, dout_a}), 36'({1'b1, 8'hA5}));
    chk("R6 no write B", {doutp_b, dout_b}, {4'h5, 32'hDEADBEEF});
    idle();
  endtask

  task automatic t_bounds();
    set_b(1, 1, 511, 32'h0, 4'h0); step();
    set_b(1, 1, 0, 32'h12345678, 4'hF); step();
    idle();
    set_a(1, 1, 2047, 8'h77, 1'b1); step();
    set_a(1, 0, 0, 8'h0, 1'b0); step();
    chk("R1 A addr 0 in B word 0", 36'({doutp_a, dout_a}), 36'({1'b1, 8'h78}));
    idle();
    set_b(1, 0, 511, 32'h0, 4'h0); step();
    chk("R1 A addr 2047 in B word 511", {doutp_b, dout_b}, {4'b1000, 32'h77000000});
    chk("R1 model agrees", {doutp_b, dout_b}, exp_b(511));
    idle();
  endtask

  task automatic t_concurrent();
    set_b(1, 1, 25, 32'h0, 4'h0); step();
    idle();
    set_a(1, 1, 100, 8'h5A, 1'b0);
    set_b(1, 1, 30, 32'h89ABCDEF, 4'h3);
    step();
    chk("R11 A write-first", 36'({doutp_a, dout_a}), 36'({1'b0, 8'h5A}));
    idle();
    set_a(1, 0, 121, 8'h0, 1'b0);
    set_b(1, 0, 25, 32'h0, 4'h0);
    step();
    chk("R11 B write landed", 36'({doutp_a, dout_a}), 36'({1'b1, 8'hCD}));
    chk("R11 A write landed", {doutp_b, dout_b}, {4'h0, 32'h0000005A});
    idle();
  endtask

  initial begin
    t_reset();
    t_write_first();
    t_read_first();
    t_narrow_to_wide();
    t_wide_to_narrow();
    t_disable();
    t_bounds();
    t_concurrent();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nvec++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule